// File: doc/BRIEF.md
# Double-Buffered Serial Port with Interrupt Flags

The block is an asynchronous 8N1 serial transmitter and receiver. Each direction has two stages: a holding register that software reads or writes, and a shift register that works on the line. A received character passes from the receive shifter into the receive holding register. A character that software writes passes from the transmit holding register into the transmit shifter once the shifter is free. Three status flags track this hand-over: receive-full, transmit-empty and transmit-end. Each flag, together with its own enable bit, drives a separate interrupt request.

Software talks to the block over a simple single-cycle register bus. The bus has four addresses: data at 0, status at 1, control at 2 and bit period at 3. Flags are cleared only by explicit writes. Writing 0 to a status bit clears that flag, and writing 1 leaves it as it is.

The transmit-end flag has a narrow meaning. It rises only when the stop bit of the shifting character finishes while the transmit holding register is still empty. It therefore tells software that it did not refill the holding register in time.

Top module: `dbuf_uart`

## Requirements
- R1: When the receiver completes a character while status bit 0 (receive-full) is 0, the data goes to the receive holding register and status bit 0 is set. The data is read at address 0.
- R2: `irq_rx_o` is 1 exactly while status bit 0 and control bit 0 are both 1.
- R3: Writing status with bit 0 = 0 clears receive-full, and writing it with bit 0 = 1 has no effect. Reception continues in the shifter meanwhile, so characters with no idle gap between them are all received.
- R4: A write to address 0 fills the transmit holding register. Writing status with bit 1 = 0 then marks that data pending (transmit-empty = 0). When the shifter is idle or finishing its stop bit, pending data loads into it and status bit 1 (transmit-empty) is set to 1.
- R5: `irq_tx_o` is 1 exactly while status bit 1 and control bit 1 are both 1.
- R6: Status bit 2 (transmit-end) is set when the stop bit ends while transmit-empty is 1. `irq_te_o` is 1 exactly while status bit 2 and control bit 2 are both 1.
- R7: If data is pending when the stop bit ends, the next start bit follows in the very next cycle with no idle gap, and transmit-end stays 0.
- R8: Writing status with bit 1 = 0 also clears transmit-end. A flag that hardware sets in the same cycle as a software clear stays set.
- R9: A character that completes while receive-full is 1 is dropped. The holding register keeps its old value, status bit 3 (overrun) is set, and no extra interrupt is raised. Writing status with bit 3 = 0 clears overrun.
- R10: A frame is one start bit (0), 8 data bits with the least significant bit first, and one stop bit (1). Each bit lasts the value at address 3 in clocks, which must be 4 or more and resets to 16. The receiver samples each bit at mid-bit, timed from the start edge.
- R11: After reset, status reads 0x06 (transmit-empty = 1, transmit-end = 1), control reads 0, `txd_o` is 1 and all interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| irq_rx_o | output | 1 | Receive-full interrupt request |
| irq_tx_o | output | 1 | Transmit-empty interrupt request |
| irq_te_o | output | 1 | Transmit-end interrupt request |

## Verification
The collisions of interest happen when a software clear of transmit-empty lands in the same clock edge where hardware sets a flag. In the first case, the transmit shifter reloads pending data at that edge and sets transmit-empty. In the second case, the stop bit ends with transmit-empty at 1 and sets transmit-end. The bench drives each collision from its own behavioural line model: it waits for the cycle in which exactly one bit-clock of the frame remains, then issues the status write so that it lands on the critical edge. The results are judged at the ports, by reading status and by comparing the line and interrupt outputs against the model on every clock. In both cases the flag that hardware set must stay set.

// File: rtl/dbuf_uart_pkg.sv
package dbuf_uart_pkg;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_PER  = 2'd3;

  localparam int unsigned ST_RXF = 0;
  localparam int unsigned ST_TXE = 1;
  localparam int unsigned ST_TXD = 2;
  localparam int unsigned ST_OVR = 3;

  localparam int unsigned CT_RIE = 0;
  localparam int unsigned CT_TIE = 1;
  localparam int unsigned CT_DIE = 2;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/dbuf_uart_rx.sv
module dbuf_uart_rx
  import dbuf_uart_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic [DIV_W-1:0]  per_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic              s1_q, s2_q;
  rx_state_e         st_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic [DIV_W-1:0]  half;
  logic              bit_end, half_end;

  assign half     = per_i >> 1;
  assign bit_end  = (cnt_q == per_i - DIV_W'(1));
  assign half_end = (cnt_q == half - DIV_W'(1));
  assign done_o   = (st_q == RX_STOP) && bit_end;
  assign data_o   = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rxd_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
    end else begin
      unique case (st_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (!s2_q) st_q <= RX_START;
        end
        RX_START: begin
          if (half_end) begin
            cnt_q <= '0;
            idx_q <= '0;
            st_q  <= s2_q ? RX_IDLE : RX_DATA;
          end else begin
            cnt_q <= cnt_q + DIV_W'(1);
          end
        end
        RX_DATA: begin
          if (bit_end) begin
            cnt_q <= '0;
            sh_q  <= {s2_q, sh_q[DATA_W-1:1]};
            idx_q <= idx_q + IDX_W'(1);
            if (idx_q == IDX_W'(DATA_W-1)) st_q <= RX_STOP;
          end else begin
            cnt_q <= cnt_q + DIV_W'(1);
          end
        end
        RX_STOP: begin
          if (bit_end) begin
            cnt_q <= '0;
            st_q  <= RX_IDLE;
          end else begin
            cnt_q <= cnt_q + DIV_W'(1);
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  per_i,
  input  logic              pend_i,
  input  logic [DATA_W-1:0] tdr_i,
  output logic              load_o,
  output logic              done_o,
  output logic              txd_o
);
  localparam int unsigned FRM_W = DATA_W + 2;
  localparam int unsigned IDX_W = $clog2(FRM_W);

  logic             busy_q;
  logic [DIV_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [FRM_W-1:0] sh_q;
  logic             bit_end;

  assign bit_end = busy_q && (cnt_q == per_i - DIV_W'(1));
  assign done_o  = bit_end && (idx_q == IDX_W'(FRM_W-1));
  // reload on the stop-bit end cycle keeps frames gapless
  assign load_o  = pend_i && (!busy_q || done_o);
  assign txd_o   = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '1;
    end else if (load_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= {1'b1, tdr_i, 1'b0};
    end else if (done_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (bit_end) begin
      cnt_q  <= '0;
      idx_q  <= idx_q + IDX_W'(1);
      sh_q   <= {1'b1, sh_q[FRM_W-1:1]};
    end else if (busy_q) begin
      cnt_q  <= cnt_q + DIV_W'(1);
    end
  end

  AST_TX_GAPLESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pend_i) |=> (busy_q && !txd_o)) else $error("gap after frame"); // R7
endmodule

// File: rtl/dbuf_uart_regs.sv
module dbuf_uart_regs
  import dbuf_uart_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned DIV_RST = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              tx_load_i,
  input  logic              tx_done_i,
  output logic [DATA_W-1:0] tdr_o,
  output logic              pend_o,
  output logic [DIV_W-1:0]  per_o,
  output logic              irq_rx_o,
  output logic              irq_tx_o,
  output logic              irq_te_o
);
  logic [DATA_W-1:0] rdr_q, tdr_q;
  logic [DIV_W-1:0]  per_q;
  logic [2:0]        ctrl_q;
  logic              rdrf_q, ovr_q, tdre_q, tend_q;
  logic              wr_data, wr_stat, wr_ctrl, wr_per;

  assign wr_data = sel_i && wr_i && (addr_i == ADDR_DATA);
  assign wr_stat = sel_i && wr_i && (addr_i == ADDR_STAT);
  assign wr_ctrl = sel_i && wr_i && (addr_i == ADDR_CTRL);
  assign wr_per  = sel_i && wr_i && (addr_i == ADDR_PER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdr_q  <= '0;
      ctrl_q <= '0;
      per_q  <= DIV_W'(DIV_RST);
    end else begin
      if (wr_data) tdr_q  <= wdata_i;
      if (wr_ctrl) ctrl_q <= wdata_i[2:0];
      if (wr_per)  per_q  <= wdata_i[DIV_W-1:0];
    end
  end

  // hardware set has priority over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdr_q  <= '0;
      rdrf_q <= 1'b0;
      ovr_q  <= 1'b0;
      tdre_q <= 1'b1;
      tend_q <= 1'b1;
    end else begin
      if (rx_done_i && !rdrf_q) begin
        rdr_q  <= rx_data_i;
        rdrf_q <= 1'b1;
      end else if (wr_stat && !wdata_i[ST_RXF]) begin
        rdrf_q <= 1'b0;
      end
      if (rx_done_i && rdrf_q)                ovr_q <= 1'b1;
      else if (wr_stat && !wdata_i[ST_OVR])   ovr_q <= 1'b0;
      if (tx_load_i)                          tdre_q <= 1'b1;
      else if (wr_stat && !wdata_i[ST_TXE])   tdre_q <= 1'b0;
      if (tx_done_i && tdre_q)                tend_q <= 1'b1;
      else if (wr_stat && !wdata_i[ST_TXE])   tend_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_DATA: rdata_o = rdr_q;
      ADDR_STAT: begin
        rdata_o[ST_RXF] = rdrf_q;
        rdata_o[ST_TXE] = tdre_q;
        rdata_o[ST_TXD] = tend_q;
        rdata_o[ST_OVR] = ovr_q;
      end
      ADDR_CTRL: rdata_o[2:0] = ctrl_q;
      default:   rdata_o = DATA_W'(per_q);
    endcase
  end

  assign tdr_o    = tdr_q;
  assign pend_o   = !tdre_q;
  assign per_o    = per_q;
  assign irq_rx_o = rdrf_q && ctrl_q[CT_RIE];
  assign irq_tx_o = tdre_q && ctrl_q[CT_TIE];
  assign irq_te_o = tend_q && ctrl_q[CT_DIE];

  AST_RX_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && !rdrf_q) |=> (rdrf_q && rdr_q == $past(rx_data_i))) else $error("rx capture"); // R1
  AST_OVR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && rdrf_q) |=> (ovr_q && rdrf_q && $stable(rdr_q))) else $error("overrun"); // R9
  AST_LOAD_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_i |=> tdre_q) else $error("load flag"); // R4
  AST_TEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && tdre_q) |=> tend_q) else $error("tend set"); // R6
  AST_TEND_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tend_q) |-> $past(tx_done_i && tdre_q)) else $error("tend cause"); // R7
endmodule

// File: rtl/dbuf_uart.sv
module dbuf_uart
  import dbuf_uart_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned DIV_RST = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              irq_rx_o,
  output logic              irq_tx_o,
  output logic              irq_te_o
);
  logic              rx_done, tx_load, tx_done, pend;
  logic [DATA_W-1:0] rx_data, tdr;
  logic [DIV_W-1:0]  per;

  dbuf_uart_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) regs_i (
    .clk_i, .rst_ni, .sel_i, .wr_i, .addr_i, .wdata_i, .rdata_o,
    .rx_done_i(rx_done), .rx_data_i(rx_data),
    .tx_load_i(tx_load), .tx_done_i(tx_done),
    .tdr_o(tdr), .pend_o(pend), .per_o(per),
    .irq_rx_o, .irq_tx_o, .irq_te_o
  );

  dbuf_uart_rx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) rx_i (
    .clk_i, .rst_ni, .rxd_i, .per_i(per),
    .done_o(rx_done), .data_o(rx_data)
  );

  dbuf_uart_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) tx_i (
    .clk_i, .rst_ni, .per_i(per), .pend_i(pend), .tdr_i(tdr),
    .load_o(tx_load), .done_o(tx_done), .txd_o
  );
endmodule

// File: tb/dbuf_uart_tb_top.sv
module dbuf_uart_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       rxd = 1'b1;
  logic       txd, irq_rx, irq_tx, irq_te;

  int n_chk = 0, n_err = 0;

  // behavioural model of the transmit side and of the bench's own writes
  int   m_per;
  bit   m_pend, m_tend;
  bit [7:0] m_tdr;
  bit [2:0] m_ctrl;
  bit   line_q[$];
  bit   e_rxf, e_ovr;

  always #5 clk = ~clk;

  dbuf_uart dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd), .txd_o(txd),
    .irq_rx_o(irq_rx), .irq_tx_o(irq_tx), .irq_te_o(irq_te)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_per = 16; m_pend = 0; m_tend = 1; m_tdr = 0; m_ctrl = 0;
      line_q.delete();
    end else begin
      automatic bit had  = (line_q.size() != 0);
      automatic bit done, load, wclr;
      automatic bit old_pend = m_pend;
      automatic bit [7:0] old_tdr = m_tdr;
      if (had) void'(line_q.pop_front());
      done = had && (line_q.size() == 0);
      load = (line_q.size() == 0) && old_pend;
      wclr = sel && wr && addr == 2'd1 && !wdata[1];
      if (load) begin
        for (int f = 0; f < 10; f++) begin
          automatic bit b = (f == 0) ? 1'b0 : (f == 9) ? 1'b1 : old_tdr[f-1];
          for (int k = 0; k < m_per; k++) line_q.push_back(b);
        end
      end
      if (load) m_pend = 0; else if (wclr) m_pend = 1;
      if (done && !old_pend) m_tend = 1; else if (wclr) m_tend = 0;
      if (sel && wr && addr == 2'd0) m_tdr = wdata;
      if (sel && wr && addr == 2'd2) m_ctrl = wdata[2:0];
      if (sel && wr && addr == 2'd3) m_per = int'(wdata);
    end
  end

  // every-clock comparison of line and transmit interrupts
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10 txd", txd, (line_q.size() != 0) ? line_q[0] : 1'b1);
      chk("R5 irq_tx", irq_tx, !m_pend && m_ctrl[1]);
      chk("R6 irq_te", irq_te, m_tend && m_ctrl[2]);
    end
  end

  task automatic wr_now(logic [1:0] a, logic [7:0] d);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_now(a, d);
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; sel = 1; wr = 0;
    #1 d = rdata;
    sel = 0;
  endtask

  function automatic logic [7:0] exp_stat();
    return {4'b0, e_ovr, m_tend, !m_pend, e_rxf};
  endfunction

  task automatic chk_stat(string tag);
    logic [7:0] d;
    rd_reg(2'd1, d);
    chk(tag, d, exp_stat());
  endtask

  task automatic send_rx(logic [7:0] b);
    for (int i = 0; i < 10; i++) begin
      rxd = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : b[i-1];
      repeat (m_per) @(negedge clk);
    end
  endtask

  task automatic wait_tx_idle();
    while (line_q.size() != 0 || m_pend) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset state
    rd_reg(2'd1, d); chk("R11 status", d, 8'h06);
    rd_reg(2'd2, d); chk("R11 ctrl", d, 8'h00);
    rd_reg(2'd3, d); chk("R10 period reset", d, 8'd16);
    chk("R11 txd", txd, 1'b1);
    chk("R11 irq_rx", irq_rx, 1'b0);

    wr_reg(2'd3, 8'd8);
    wr_reg(2'd2, 8'h07);
    rd_reg(2'd3, d); chk("R10 period", d, 8'd8);

    // R4 single character, R6 end flag afterwards
    wr_reg(2'd0, 8'hA5);
    wr_reg(2'd1, 8'hFD);
    chk_stat("R4 pending");
    wait_tx_idle();
    chk_stat("R6 end set");
    chk("R6 irq_te", irq_te, 1'b1);

    // R7 refill in time: gapless, no end flag
    wr_reg(2'd0, 8'h3C);
    wr_reg(2'd1, 8'hFD);
    while (m_pend) @(negedge clk);
    wr_reg(2'd0, 8'hC3);
    wr_reg(2'd1, 8'hFD);
    while (!(line_q.size() == 1 && m_pend)) @(negedge clk);
    @(negedge clk);
    rd_reg(2'd1, d); chk("R7 end stays 0", d[2], 1'b0);
    wait_tx_idle();
    chk_stat("R6 end after pair");

    // R8 load collides with a clear of transmit-empty
    wr_reg(2'd0, 8'h5A);
    wr_reg(2'd1, 8'hFD);
    while (m_pend) @(negedge clk);
    wr_reg(2'd0, 8'h11);
    wr_reg(2'd1, 8'hFD);
    while (!(line_q.size() == 1 && m_pend)) @(negedge clk);
    wr_now(2'd1, 8'hFD);
    rd_reg(2'd1, d); chk("R8 empty set wins", d[1], 1'b1);
    // R8 end flag set collides with a clear
    while (!(line_q.size() == 1 && !m_pend)) @(negedge clk);
    wr_now(2'd1, 8'hFD);
    rd_reg(2'd1, d); chk("R8 end set wins", d[2], 1'b1);
    wait_tx_idle();
    chk_stat("R8 after collisions");

    // R1 R2 receive
    send_rx(8'h96);
    e_rxf = 1;
    chk("R2 irq_rx", irq_rx, 1'b1);
    rd_reg(2'd0, d); chk("R1 rx data", d, 8'h96);
    chk_stat("R1 status");
    wr_reg(2'd1, 8'hFF);
    chk_stat("R3 write 1 no effect");
    wr_reg(2'd2, 8'h06);
    chk("R2 irq_rx disabled", irq_rx, 1'b0);
    wr_reg(2'd2, 8'h07);
    wr_reg(2'd1, 8'hFE);
    e_rxf = 0;
    chk_stat("R3 cleared");
    chk("R3 irq_rx low", irq_rx, 1'b0);

    // R3 back-to-back characters
    fork
      begin send_rx(8'h01); send_rx(8'h80); end
      begin
        repeat (82) @(negedge clk);
        rd_reg(2'd0, d); chk("R3 first of pair", d, 8'h01);
        wr_reg(2'd1, 8'hFE);
      end
    join
    e_rxf = 1;
    rd_reg(2'd0, d); chk("R3 second of pair", d, 8'h80);
    chk_stat("R3 pair status");

    // R9 overrun
    send_rx(8'h77);
    e_ovr = 1;
    rd_reg(2'd0, d); chk("R9 data kept", d, 8'h80);
    chk_stat("R9 overrun set");
    chk("R9 irq_rx", irq_rx, 1'b1);
    wr_reg(2'd1, 8'hF7);
    e_ovr = 0;
    chk_stat("R9 overrun cleared");
    wr_reg(2'd1, 8'hFE);
    e_rxf = 0;
    chk_stat("R3 final clear");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule